// File: doc/BRIEF.md
# Store Data Receive Queue

This block sits on the core side of a coprocessor link and takes in store data beats. Each beat arrives with a one-cycle valid strobe, a small tag and a wide data word. The queue holds the beats in arrival order until a load/store unit removes them through a valid/ready pop port. The pop port shows the tag and the data of the oldest entry.

The sender reacts to the stop output only after some delay. For that reason stop is raised early, while one slot is still free, so that a beat already on its way still has a place to land. A beat that arrives when every slot is taken is refused, and a sticky error flag records the loss.

A flush request does not clear the queue at once. The request passes through a short delay line, and the contents are cleared only when it comes out the other end. Beats that were already in flight when the flush was asked for are therefore removed as well.

Top module: `sdq_store_queue`

## Requirements
- R1: A beat is captured at a clock edge where `in_valid` is high and the queue is not full. The 4-bit `in_tag` and the 64-bit `in_data` are stored together and later come out unchanged on `pop_tag` and `pop_data`.
- R2: Entries leave in the order they were captured, including after the slot pointers wrap around.
- R3: `stop` is high whenever two or more entries are held, and low whenever fewer than two are held. It therefore falls as soon as pops bring the occupancy below two.
- R4: The queue holds exactly three entries. A beat that arrives in the cycle after `stop` rises is still captured, so three back-to-back beats are all kept.
- R5: A beat with `in_valid` high that arrives while three entries are held is discarded, and `overflow` becomes 1. `overflow` stays 1 until reset.
- R6: Values on `in_tag` and `in_data` while `in_valid` is low are never captured. A beat that the sender keeps on the lines after its strobe therefore enters the queue only once.
- R7: `pop_valid` is high exactly when the queue is non-empty. An entry is removed at an edge where both `pop_valid` and `pop_ready` are high. While `pop_ready` is low, the head entry stays unchanged.
- R8: A flush requested at edge E takes effect at edge E+2. Every entry is cleared, including beats captured at E and E+1, and the queue is empty after E+2.
- R9: At the edge where a flush takes effect, a push or pop in that same cycle has no effect. After that edge the queue is empty and accepts new beats normally.
- R10: Reset is synchronous and active high. It empties the queue and drives `stop` and `overflow` low.
- R11: Fullness is judged on the occupancy before the edge. A beat that arrives while the queue is full is refused even when a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat strobe from the coprocessor |
| in_tag | input | 4 | Tag of the incoming beat |
| in_data | input | 64 | Data word of the incoming beat |
| stop | output | 1 | Asks the sender to pause transfers |
| flush_req | input | 1 | Flush request; clears the queue two cycles later |
| pop_valid | output | 1 | Head entry is present |
| pop_ready | input | 1 | Consumer takes the head entry |
| pop_tag | output | 4 | Tag of the head entry |
| pop_data | output | 64 | Data word of the head entry |
| overflow | output | 1 | Sticky flag: a beat was refused because the queue was full |

## Verification
The bench builds the block with its defaults: three slots, a stop threshold of two and a flush delay of two. With only three slots, full occupancy, a refused beat and pointer wrap-around all occur within the first dozen cycles, so the vector table covers them. The short delay lets a directed test place beats on each edge of the flush window, with a pop on the edge where the flush takes effect.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

    localparam int TAG_W  = 4;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } beat_t;

    typedef enum logic [1:0] {
        OCC_HOLD  = 2'b00,
        OCC_INC   = 2'b01,
        OCC_DEC   = 2'b10,
        OCC_CLEAR = 2'b11
    } occ_op_e;

    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic occ_op_e occ_op(input logic clear, input logic push,
                                       input logic pop);
        if (clear)
            return OCC_CLEAR;
        if (push && !pop)
            return OCC_INC;
        if (pop && !push)
            return OCC_DEC;
        return OCC_HOLD;
    endfunction

endpackage

// File: rtl/sdq_flush_pipe.sv
module sdq_flush_pipe #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic flush_req,
    output logic flush_apply
);
    generate
        if (DELAY == 0) begin : g_direct
            assign flush_apply = flush_req;
        end else begin : g_line
            logic [DELAY-1:0] line_q;
            always_ff @(posedge clk) begin
                if (rst)
                    line_q <= '0;
                else if (DELAY == 1)
                    line_q <= flush_req;
                else
                    line_q <= {line_q[DELAY-2:0], flush_req};
            end
            assign flush_apply = line_q[DELAY-1];
        end
    endgenerate
endmodule

// File: rtl/sdq_ring.sv
module sdq_ring
    import sdq_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  beat_t            beat_in,
    output beat_t            head,
    output logic [CNT_W-1:0] occupancy
);
    localparam int PTR_W = ptr_bits(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    beat_t            slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    occ_op_e          op;

    assign op = occ_op(clear, push, pop);

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && !clear && wr_ptr == PTR_W'(s))
                    slots[s] <= beat_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occupancy <= '0;
        end else begin
            unique case (op)
                OCC_CLEAR: occupancy <= '0;
                OCC_INC:   occupancy <= occupancy + CNT_W'(1);
                OCC_DEC:   occupancy <= occupancy - CNT_W'(1);
                default:   occupancy <= occupancy;
            endcase
        end
    end

    assign head = slots[rd_ptr];
endmodule

// File: rtl/sdq_flow.sv
module sdq_flow #(
    parameter int DEPTH      = 3,
    parameter int STOP_LEVEL = 2,
    parameter int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             clear,
    input  logic [CNT_W-1:0] occupancy,
    output logic             accept,
    output logic             stop,
    output logic             overflow
);
    logic full;
    logic refused;

    assign full    = (occupancy >= CNT_W'(DEPTH));
    assign accept  = in_valid && !full;
    assign refused = in_valid && full && !clear;
    assign stop    = (occupancy >= CNT_W'(STOP_LEVEL));

    always_ff @(posedge clk) begin
        if (rst)
            overflow <= 1'b0;
        else if (refused)
            overflow <= 1'b1;
    end
endmodule

// File: rtl/sdq_store_queue.sv
module sdq_store_queue
    import sdq_pkg::*;
#(
    parameter int DEPTH       = 3,
    parameter int STOP_LEVEL  = 2,
    parameter int FLUSH_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    output logic              stop,
    input  logic              flush_req,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [TAG_W-1:0]  pop_tag,
    output logic [DATA_W-1:0] pop_data,
    output logic              overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             flush_apply;
    logic             accept;
    logic             do_push, do_pop;
    logic [CNT_W-1:0] occupancy;
    beat_t            beat_in, head;

    assign beat_in = '{tag: in_tag, data: in_data};

    sdq_flush_pipe #(.DELAY(FLUSH_DELAY)) flush_i (
        .clk         (clk),
        .rst         (rst),
        .flush_req   (flush_req),
        .flush_apply (flush_apply)
    );

    sdq_flow #(.DEPTH(DEPTH), .STOP_LEVEL(STOP_LEVEL), .CNT_W(CNT_W)) flow_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .clear     (flush_apply),
        .occupancy (occupancy),
        .accept    (accept),
        .stop      (stop),
        .overflow  (overflow)
    );

    assign pop_valid = (occupancy != '0);
    assign do_push   = accept && !flush_apply;
    assign do_pop    = pop_valid && pop_ready && !flush_apply;

    sdq_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ring_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (flush_apply),
        .push      (do_push),
        .pop       (do_pop),
        .beat_in   (beat_in),
        .head      (head),
        .occupancy (occupancy)
    );

    assign pop_tag  = head.tag;
    assign pop_data = head.data;
endmodule

// File: rtl/sdq_store_queue_chk.sv
module sdq_store_queue_chk #(
    parameter int DEPTH       = 3,
    parameter int FLUSH_DELAY = 2,
    parameter int CNT_W       = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush_req,
    input logic             stop,
    input logic             overflow,
    input logic             pop_valid,
    input logic             pop_ready,
    input logic [3:0]       pop_tag,
    input logic [63:0]      pop_data,
    input logic [CNT_W-1:0] occupancy
);
    logic [FLUSH_DELAY:0] fl_seen;

    always_ff @(posedge clk) begin
        if (rst)
            fl_seen <= '0;
        else
            fl_seen <= {fl_seen[FLUSH_DELAY-1:0], flush_req};
    end

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        fl_seen[FLUSH_DELAY] |-> !pop_valid);

    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R7
    head_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_valid && !pop_ready && !fl_seen[FLUSH_DELAY-1])
        |=> (pop_valid && $stable(pop_tag) && $stable(pop_data)));

    // R3
    stop_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        stop |-> pop_valid);

    // R4
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy <= CNT_W'(DEPTH));

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!pop_valid && !stop && !overflow));
endmodule

bind sdq_store_queue sdq_store_queue_chk #(
    .DEPTH       (DEPTH),
    .FLUSH_DELAY (FLUSH_DELAY)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .flush_req (flush_req),
    .stop      (stop),
    .overflow  (overflow),
    .pop_valid (pop_valid),
    .pop_ready (pop_ready),
    .pop_tag   (pop_tag),
    .pop_data  (pop_data),
    .occupancy (occupancy)
);

// File: tb/sdq_store_queue_tb_top.sv
module sdq_store_queue_tb_top;

    typedef struct packed {
        logic       v;
        logic [3:0] tag;
        logic       rdy;
        logic       epv;
        logic [3:0] etag;
        logic       estop;
        logic       eovf;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd1, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0},
        '{1'b1, 4'd2, 1'b0, 1'b1, 4'd1, 1'b1, 1'b0},
        '{1'b1, 4'd3, 1'b0, 1'b1, 4'd1, 1'b1, 1'b0},
        '{1'b1, 4'd4, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1},
        '{1'b0, 4'd4, 1'b1, 1'b1, 4'd2, 1'b1, 1'b1},
        '{1'b0, 4'd4, 1'b1, 1'b1, 4'd3, 1'b0, 1'b1},
        '{1'b1, 4'd5, 1'b1, 1'b1, 4'd5, 1'b0, 1'b1},
        '{1'b0, 4'd6, 1'b0, 1'b1, 4'd5, 1'b0, 1'b1},
        '{1'b0, 4'd6, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1},
        '{1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_tag = '0;
    logic [63:0] in_data = '0;
    logic        stop;
    logic        flush_req = 1'b0;
    logic        pop_valid;
    logic        pop_ready = 1'b0;
    logic [3:0]  pop_tag;
    logic [63:0] pop_data;
    logic        overflow;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sdq_store_queue dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_tag    (in_tag),
        .in_data   (in_data),
        .stop      (stop),
        .flush_req (flush_req),
        .pop_valid (pop_valid),
        .pop_ready (pop_ready),
        .pop_tag   (pop_tag),
        .pop_data  (pop_data),
        .overflow  (overflow)
    );

    function automatic logic [63:0] pattern(input logic [3:0] t);
        return {16{t}} ^ 64'h0123_4567_89AB_CDEF;
    endfunction

    task automatic check(input string req, input logic epv, input logic [3:0] etag,
                         input logic estop, input logic eovf);
        logic [70:0] act, exp;
        act = {pop_valid, pop_valid ? pop_tag : 4'd0,
               pop_valid ? pop_data : 64'd0, stop, overflow};
        exp = {epv, epv ? etag : 4'd0, epv ? pattern(etag) : 64'd0, estop, eovf};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual pv=%b tag=%h data=%h stop=%b ovf=%b expected pv=%b tag=%h data=%h stop=%b ovf=%b",
                     req, act[70], act[69:66], act[65:2], act[1], act[0],
                     exp[70], exp[69:66], exp[65:2], exp[1], exp[0]);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] t, input logic rdy,
                        input logic fl);
        in_valid  = v;
        in_tag    = t;
        in_data   = pattern(t);
        pop_ready = rdy;
        flush_req = fl;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 4'd0, 1'b0, 1'b0);
        step(1'b0, 4'd0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string vreq [NV] = '{"R1 R3", "R3 R4", "R4", "R5", "R6 R7",
                             "R3 R7", "R2 R7", "R6", "R7", "R7"};
        @(negedge clk);
        do_reset();
        // R10: state after reset
        check("R10", 1'b0, 4'd0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].v, VECS[i].tag, VECS[i].rdy, 1'b0);
            check(vreq[i], VECS[i].epv, VECS[i].etag, VECS[i].estop, VECS[i].eovf);
        end

        do_reset();
        check("R10", 1'b0, 4'd0, 1'b0, 1'b0);

        // R8 R9: beats on each edge of the flush window, pop at the clear edge
        step(1'b1, 4'hA, 1'b0, 1'b0);
        check("R1", 1'b1, 4'hA, 1'b0, 1'b0);
        step(1'b1, 4'hB, 1'b0, 1'b1);
        check("R8", 1'b1, 4'hA, 1'b1, 1'b0);
        step(1'b1, 4'hC, 1'b0, 1'b0);
        check("R8", 1'b1, 4'hA, 1'b1, 1'b0);
        step(1'b1, 4'hD, 1'b1, 1'b0);
        check("R8 R9", 1'b0, 4'd0, 1'b0, 1'b0);
        step(1'b1, 4'hE, 1'b0, 1'b0);
        check("R9", 1'b1, 4'hE, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R9", 1'b0, 4'd0, 1'b0, 1'b0);

        // R11: full queue refuses a beat even with a pop at the same edge
        step(1'b1, 4'd7, 1'b0, 1'b0);
        step(1'b1, 4'd8, 1'b0, 1'b0);
        step(1'b1, 4'd9, 1'b0, 1'b0);
        check("R4", 1'b1, 4'd7, 1'b1, 1'b0);
        step(1'b1, 4'hF, 1'b1, 1'b0);
        check("R11", 1'b1, 4'd8, 1'b1, 1'b1);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R11", 1'b1, 4'd9, 1'b0, 1'b1);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R11", 1'b0, 4'd0, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule